// File: doc/BRIEF.md
# Comparator Edge Flag and Request Router

This block watches an already conditioned, clock-synchronous comparator output and records its transitions in two sticky flags, one for upward and one for downward transitions. Each flag is paired with its own enable; an enabled and set flag produces a service request. A routing bit decides whether that request goes to the processor as an interrupt line or to a transfer engine as a DMA request.

Software clears flags by writing ones to per-flag clear strobes. In DMA mode the transfer engine returns a completion pulse, which clears the flags whose enables were set, and that drops the DMA request. A new transition always takes priority over a clear arriving in the same cycle, so no edge is lost.

Edges are found by comparing the input against a registered copy of itself. The first sample after reset only loads that copy, so a comparator that is already high when reset ends is not reported as a rising edge.

Top module: `cmp_edge_req`

## Requirements
- R1: While rst_ni is low, and after its release until the first detected edge, rise_flag_o, fall_flag_o, irq_o and dma_req_o are all 0.
- R2: If cmp_out_i is 1 at a clock edge and was 0 at the previous clock edge (both after reset), rise_flag_o is 1 from that edge on until cleared.
- R3: If cmp_out_i is 0 at a clock edge and was 1 at the previous clock edge (both after reset), fall_flag_o is 1 from that edge on until cleared; both flags can be set together.
- R4: The first clock edge after reset release never sets a flag, whatever the level of cmp_out_i.
- R5: A flag is cleared at a clock edge where its clear strobe (clr_rise_i or clr_fall_i) is 1 and no new edge of its kind is seen; without a clear, set or acknowledge it holds its value.
- R6: When a clear (strobe or acknowledge) and a new edge of the same kind meet in one cycle, the flag stays 1.
- R7: With dma_en_i 0, irq_o = (rise_ie_i & rise_flag_o) | (fall_ie_i & fall_flag_o) combinationally, and dma_req_o is 0.
- R8: With dma_en_i 1, irq_o is 0 and dma_req_o = (rise_ie_i & rise_flag_o) | (fall_ie_i & fall_flag_o).
- R9: dma_ack_i at a clock edge with dma_en_i 1 clears each flag whose enable is 1 and leaves flags with enable 0 unchanged; with dma_en_i 0 it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_out_i | input | 1 | Conditioned comparator output, synchronous to clk_i |
| rise_ie_i | input | 1 | Rising-edge request enable |
| fall_ie_i | input | 1 | Falling-edge request enable |
| dma_en_i | input | 1 | Route requests to DMA instead of interrupt |
| clr_rise_i | input | 1 | Write-one clear of the rising flag |
| clr_fall_i | input | 1 | Write-one clear of the falling flag |
| dma_ack_i | input | 1 | Transfer completion pulse |
| rise_flag_o | output | 1 | Sticky rising-edge flag |
| fall_flag_o | output | 1 | Sticky falling-edge flag |
| irq_o | output | 1 | Processor interrupt request |
| dma_req_o | output | 1 | DMA transfer request |

## Verification
The assertions take for granted that every input is already synchronous to clk_i and stable around the rising edge, so the comparator level seen at one edge is the one the registered copy holds at the next. They also assume the enables and the DMA routing bit may change in any cycle, which is why the routing checks are written combinationally rather than over time. The stimulus changes all inputs just after the falling clock edge, walks through each directed corner (edge at release, clear against edge, acknowledge with mixed enables) and then drives random levels and strobes with reset held high.

// File: rtl/cmp_edge_pkg.sv
package cmp_edge_pkg;
  localparam int unsigned NUM_EDGES = 2;
  typedef enum logic [0:0] {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;
  localparam int unsigned IDX_RISE = 0;
  localparam int unsigned IDX_FALL = 1;
endpackage

// File: rtl/cmp_edge_detect.sv
module cmp_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;
  logic vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= cmp_i;
      vld_q  <= 1'b1;
    end
  end

  // first sample after reset only primes the history register
  assign rise_o = vld_q &  cmp_i & ~prev_q;
  assign fall_o = vld_q & ~cmp_i &  prev_q;

  assert_first_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q |-> (!rise_o && !fall_o));
  assert_edges_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/cmp_edge_flag.sv
module cmp_edge_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;  // edge beats clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_edge_sets_R2_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  assert_edge_beats_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> flag_o);
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/cmp_edge_route.sv
module cmp_edge_route
  import cmp_edge_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_EDGES-1:0] flag_i,
  input  logic [NUM_EDGES-1:0] ie_i,
  input  logic                 dma_en_i,
  input  logic                 dma_ack_i,
  output logic [NUM_EDGES-1:0] ack_clr_o,
  output logic                 irq_o,
  output logic                 dma_req_o
);
  logic any_req;

  assign any_req   = |(flag_i & ie_i);
  assign irq_o     = any_req & ~dma_en_i;
  assign dma_req_o = any_req &  dma_en_i;
  assign ack_clr_o = {NUM_EDGES{dma_ack_i & dma_en_i}} & ie_i;

  assert_irq_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_en_i |-> !irq_o);
  assert_dma_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |-> !dma_req_o);
  assert_one_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({irq_o, dma_req_o}) <= 1);
  assert_ack_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |-> (ack_clr_o == '0));
endmodule

// File: rtl/cmp_edge_req.sv
module cmp_edge_req
  import cmp_edge_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_out_i,
  input  logic rise_ie_i,
  input  logic fall_ie_i,
  input  logic dma_en_i,
  input  logic clr_rise_i,
  input  logic clr_fall_i,
  input  logic dma_ack_i,
  output logic rise_flag_o,
  output logic fall_flag_o,
  output logic irq_o,
  output logic dma_req_o
);
  logic [NUM_EDGES-1:0] edge_set;
  logic [NUM_EDGES-1:0] sw_clr;
  logic [NUM_EDGES-1:0] ack_clr;
  logic [NUM_EDGES-1:0] flags;
  logic [NUM_EDGES-1:0] ie;

  cmp_edge_detect u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmp_i  (cmp_out_i),
    .rise_o (edge_set[IDX_RISE]),
    .fall_o (edge_set[IDX_FALL])
  );

  assign sw_clr[IDX_RISE] = clr_rise_i;
  assign sw_clr[IDX_FALL] = clr_fall_i;
  assign ie[IDX_RISE]     = rise_ie_i;
  assign ie[IDX_FALL]     = fall_ie_i;

  for (genvar g = 0; g < NUM_EDGES; g++) begin : g_flag
    cmp_edge_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (edge_set[g]),
      .clr_i  (sw_clr[g] | ack_clr[g]),
      .flag_o (flags[g])
    );
  end

  cmp_edge_route u_route (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flag_i    (flags),
    .ie_i      (ie),
    .dma_en_i  (dma_en_i),
    .dma_ack_i (dma_ack_i),
    .ack_clr_o (ack_clr),
    .irq_o     (irq_o),
    .dma_req_o (dma_req_o)
  );

  assign rise_flag_o = flags[IDX_RISE];
  assign fall_flag_o = flags[IDX_FALL];

  assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ack_i && dma_en_i && rise_ie_i && !clr_rise_i && !edge_set[IDX_RISE]) |=> !rise_flag_o);
  assert_ack_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ack_i && !fall_ie_i && !clr_fall_i && fall_flag_o) |=> fall_flag_o);
  assert_irq_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_en_i && rise_ie_i && rise_flag_o) |-> irq_o);
endmodule

// File: tb/cmp_edge_req_tb.sv
module cmp_edge_req_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp = 1'b0, rise_ie = 1'b0, fall_ie = 1'b0, dma_en = 1'b0;
  logic clr_r = 1'b0, clr_f = 1'b0, ack = 1'b0;
  logic rise_flag, fall_flag, irq, dma_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference state
  bit m_vld, m_prev, m_rise, m_fall;

  always #2.5 clk = ~clk;

  cmp_edge_req dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmp_out_i(cmp),
    .rise_ie_i(rise_ie), .fall_ie_i(fall_ie), .dma_en_i(dma_en),
    .clr_rise_i(clr_r), .clr_fall_i(clr_f), .dma_ack_i(ack),
    .rise_flag_o(rise_flag), .fall_flag_o(fall_flag),
    .irq_o(irq), .dma_req_o(dma_req)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld <= 0; m_prev <= 0; m_rise <= 0; m_fall <= 0;
    end else begin
      bit er, ef, ar, af;
      er = m_vld && cmp && !m_prev;
      ef = m_vld && !cmp && m_prev;
      ar = ack && dma_en && rise_ie;
      af = ack && dma_en && fall_ie;
      m_rise <= er ? 1'b1 : ((clr_r || ar) ? 1'b0 : m_rise);
      m_fall <= ef ? 1'b1 : ((clr_f || af) ? 1'b0 : m_fall);
      m_prev <= cmp;
      m_vld  <= 1'b1;
    end
  end

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      bit req;
      @(negedge clk); #1;
      req = (rise_ie && m_rise) || (fall_ie && m_fall);
      chk("rise_flag", rise_flag, m_rise);
      chk("fall_flag", fall_flag, m_fall);
      chk("irq", irq, req && !dma_en);
      chk("dma_req", dma_req, req && dma_en);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset holds everything low
    tag = "R1"; cmp = 1; rise_ie = 1; fall_ie = 1;
    tick(3);
    rst_n = 1;
    // R4 input already high at release: no rise reported
    tag = "R4"; tick(3);
    tag = "R3"; cmp = 0; tick(2);
    tag = "R2"; cmp = 1; tick(2);
    rise_ie = 0; fall_ie = 0;
    tag = "R5"; clr_r = 1; tick(); clr_r = 0; tick(2);
    tag = "R6"; cmp = 0; clr_f = 1; tick(); clr_f = 0; tick();
    tag = "R5"; clr_f = 1; tick(); clr_f = 0; tick();
    tag = "R7"; rise_ie = 1; cmp = 1; tick(2);
    rise_ie = 0; fall_ie = 1; tick();
    cmp = 0; tick(2);
    clr_f = 1; tick(); clr_f = 0; tick();
    tag = "R8"; cmp = 1; tick(); dma_en = 1; tick(2);
    rise_ie = 1; tick();
    tag = "R9"; cmp = 0; tick(); // both flags set now
    rise_ie = 0; fall_ie = 1; ack = 1; tick(); ack = 0; tick(2);
    dma_en = 0; rise_ie = 1; ack = 1; tick(); ack = 0; tick();
    dma_en = 1; ack = 1; tick(); ack = 0; tick();
    tag = "R6"; cmp = 1; tick(); cmp = 0; tick(); cmp = 1; ack = 1; tick(); ack = 0; tick();
    tag = "R2 R3 R5 R7 R8 R9";
    for (int k = 0; k < 400; k++) begin
      cmp = $urandom_range(0, 1); rise_ie = $urandom_range(0, 1);
      fall_ie = $urandom_range(0, 1); dma_en = $urandom_range(0, 1);
      clr_r = ($urandom_range(0, 5) == 0); clr_f = ($urandom_range(0, 5) == 0);
      ack = ($urandom_range(0, 3) == 0);
      tick();
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule